// File: doc/BRIEF.md
# Iterative Min-Sum LDPC Decoder (10-bit block)

This block decodes one 10-bit block of a rate-1/2 low-density parity-check code. The code has five parity checks, each over six bits, and every bit is covered by three checks. The block takes ten signed soft values and passes messages between bit nodes and check nodes. Check nodes use the min-sum rule, bit nodes combine by saturating addition, and the block runs up to a fixed number of iterations. One full iteration (all check nodes, then all bit nodes) finishes on every clock edge.

Making hard decisions and testing the parity checks is the expensive part of each iteration. That step runs only on iterations where an external controller raises `chk_en_i`. A controller that knows the channel quality can hold this step off until decoding has a realistic chance of having converged. On the last allowed iteration the step always runs, so a result is always delivered. The decoded word, a success flag and the number of iterations used are registered and held until the next block finishes.

Top module: `ldpc_mp_dec`

## Requirements
- R1: While reset is asserted and after it is released, `hard_o`, `ok_o`, `iters_o` and `done_o` are all zero until the first block finishes.
- R2: A `start_i` pulse seen at a clock edge while idle captures `llr_i`. The first iteration happens on the next edge. If a block finishes after k iterations, `done_o` is high exactly k cycles after the capturing edge.
- R3: Soft values are 6-bit signed and saturate symmetrically to ±31, and a captured input of -32 is treated as -31. A check-to-bit message has the sign product and the smallest magnitude of the other five bit-to-check messages on that check. A zero counts as positive.
- R4: The posterior of a bit is its captured soft value plus its three incoming check messages. The bit-to-check message leaves out the destination check. The hard decision is 1 when the posterior is above zero, and 0 when it is zero or below.
- R5: On an evaluated iteration where every parity check of the tentative word is satisfied, the block finishes with `ok_o` high and `iters_o` equal to that iteration number (first iteration = 1).
- R6: On an iteration where `chk_en_i` is low and the limit is not reached, no decisions are made and decoding continues, even if the tentative word would already be a codeword.
- R7: Iteration 50 (`MAX_ITER`) is always evaluated, and it ends the block. `ok_o` then shows whether the parity checks held, so a block can finish with `ok_o` low only at the limit.
- R8: `done_o` is a single-cycle pulse. `hard_o`, `ok_o` and `iters_o` change only when `done_o` rises, and they hold between blocks.
- R9: A `start_i` pulse while a block is in progress is ignored, and so are changes on `llr_i`. The running block's result is unchanged.
- R10: Soft value n is `llr_i[6n+5:6n]`, and decision bit n is `hard_o[n]`. The checks, as sets of bit indices, are {0,1,2,5,6,9}, {0,2,4,5,7,8}, {2,3,4,6,8,9}, {1,3,4,5,7,9} and {0,1,3,6,7,8}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a block when idle |
| llr_i | input | 60 | Ten signed 6-bit soft values, value n in bits 6n+5:6n |
| chk_en_i | input | 1 | Allow decisions and parity test on the current iteration |
| hard_o | output | 10 | Decoded word, bit n is decision n |
| ok_o | output | 1 | Last block satisfied all parity checks |
| iters_o | output | 6 | Iterations used by the last block |
| done_o | output | 1 | One-cycle pulse when a block finishes |

## Verification
The properties assume a few things about the inputs. Reset is applied before the first clock edge. All inputs carry known values on every edge. `chk_en_i` is meaningful only while a block runs. Under those conditions the properties check three things: an early finish requires the enable in the finishing cycle, a failed result appears only at the limit, and a reported success is a real codeword. The stimulus changes inputs only on falling edges. It holds `start_i` for one cycle per block, except in the deliberate mid-block pulse. It drives `chk_en_i` from a per-iteration mask that is also fed to the reference model. That mask covers always-on, periodic, delayed-start and never-on patterns, so both early finishes and forced finishes at the limit occur.

// File: rtl/ldpc_mp_pkg.sv
package ldpc_mp_pkg;

   localparam int N_BITS = 10;
   localparam int M_CHK  = 5;

   // row r, bit n = column n (rows listed high index first)
   localparam logic [M_CHK-1:0][N_BITS-1:0] H_MAT = {
      10'b0111001011,
      10'b1010111010,
      10'b1101011100,
      10'b0110110101,
      10'b1001100111
   };

   function automatic int row_deg(input int r);
      int c = 0;
      for (int n = 0; n < N_BITS; n++) if (H_MAT[r][n]) c++;
      return c;
   endfunction

   function automatic int col_deg(input int n);
      int c = 0;
      for (int r = 0; r < M_CHK; r++) if (H_MAT[r][n]) c++;
      return c;
   endfunction

   function automatic int kth_col(input int r, input int k);
      int c = 0;
      int res = 0;
      for (int n = 0; n < N_BITS; n++) begin
         if (H_MAT[r][n]) begin
            if (c == k) res = n;
            c++;
         end
      end
      return res;
   endfunction

   function automatic int kth_row(input int n, input int j);
      int c = 0;
      int res = 0;
      for (int r = 0; r < M_CHK; r++) begin
         if (H_MAT[r][n]) begin
            if (c == j) res = r;
            c++;
         end
      end
      return res;
   endfunction

   // edges numbered in row-major order over the ones of the matrix
   function automatic int edge_id(input int r, input int n);
      int e = 0;
      int res = 0;
      for (int rr = 0; rr < M_CHK; rr++) begin
         for (int nn = 0; nn < N_BITS; nn++) begin
            if (H_MAT[rr][nn]) begin
               if (rr == r && nn == n) res = e;
               e++;
            end
         end
      end
      return res;
   endfunction

   function automatic int num_edges();
      int e = 0;
      for (int r = 0; r < M_CHK; r++) e += row_deg(r);
      return e;
   endfunction

   function automatic int clamp_sym(input int v, input int lim);
      return (v > lim) ? lim : ((v < -lim) ? -lim : v);
   endfunction

endpackage

// File: rtl/ldpc_chk_node.sv
module ldpc_chk_node #(
   parameter int DEG = 6,
   parameter int W   = 6
) (
   input  logic signed [W-1:0] v2c_i [DEG],
   output logic signed [W-1:0] c2v_o [DEG]
);
   localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;

   logic [W-1:0]  mag [DEG];
   logic [W-1:0]  min1, min2, pick;
   logic [IW-1:0] min_idx;
   logic          sgn_all;

   // two smallest magnitudes plus the position of the smallest
   always_comb begin
      sgn_all = 1'b0;
      min1    = '1;
      min2    = '1;
      min_idx = '0;
      for (int k = 0; k < DEG; k++) begin
         mag[k]  = v2c_i[k][W-1] ? $unsigned(-v2c_i[k]) : $unsigned(v2c_i[k]);
         sgn_all = sgn_all ^ v2c_i[k][W-1];
         if (mag[k] < min1) begin
            min2    = min1;
            min1    = mag[k];
            min_idx = IW'(k);
         end else if (mag[k] < min2) begin
            min2 = mag[k];
         end
      end
   end

   always_comb begin
      pick = '0;
      for (int k = 0; k < DEG; k++) begin
         pick     = (min_idx == IW'(k)) ? min2 : min1;
         c2v_o[k] = (sgn_all ^ v2c_i[k][W-1]) ? -$signed(pick) : $signed(pick);
      end
   end

endmodule

// File: rtl/ldpc_bit_node.sv
module ldpc_bit_node import ldpc_mp_pkg::*; #(
   parameter int DEG = 3,
   parameter int W   = 6
) (
   input  logic signed [W-1:0] ch_i,
   input  logic signed [W-1:0] c2v_i [DEG],
   output logic signed [W-1:0] v2c_o [DEG],
   output logic signed [W-1:0] post_o
);
   localparam int LIM = (1 << (W - 1)) - 1;

   int total;

   always_comb begin
      total = int'(ch_i);
      for (int k = 0; k < DEG; k++) total += int'(c2v_i[k]);
      post_o = W'(clamp_sym(total, LIM));
      for (int k = 0; k < DEG; k++)
         v2c_o[k] = W'(clamp_sym(total - int'(c2v_i[k]), LIM));
   end

endmodule

// File: rtl/ldpc_syndrome.sv
module ldpc_syndrome import ldpc_mp_pkg::*; (
   input  logic [N_BITS-1:0] word_i,
   output logic              zero_o
);
   logic [M_CHK-1:0] par;

   for (genvar r = 0; r < M_CHK; r++) begin : g_row
      assign par[r] = ^(word_i & H_MAT[r]);
   end

   assign zero_o = (par == '0);

endmodule

// File: rtl/ldpc_mp_dec.sv
module ldpc_mp_dec import ldpc_mp_pkg::*; #(
   parameter  int LLR_W    = 6,
   parameter  int MAX_ITER = 50,
   localparam int IT_W     = $clog2(MAX_ITER + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [N_BITS*LLR_W-1:0] llr_i,
   input  logic                    chk_en_i,
   output logic [N_BITS-1:0]       hard_o,
   output logic                    ok_o,
   output logic [IT_W-1:0]         iters_o,
   output logic                    done_o
);
   localparam int N_EDGE = num_edges();
   localparam int LIM    = (1 << (LLR_W - 1)) - 1;

   if (LLR_W < 3 || LLR_W > 16) begin : g_bad_width
      initial $fatal(1, "ldpc_mp_dec: LLR_W out of range");
   end
   if (MAX_ITER < 1) begin : g_bad_limit
      initial $fatal(1, "ldpc_mp_dec: MAX_ITER must be positive");
   end

   logic                    busy_q;
   logic [IT_W-1:0]         cnt_q, it_now;
   logic signed [LLR_W-1:0] ch_in [N_BITS];
   logic signed [LLR_W-1:0] ch_q  [N_BITS];
   logic signed [LLR_W-1:0] post  [N_BITS];
   logic signed [LLR_W-1:0] v2c_q  [N_EDGE];
   logic signed [LLR_W-1:0] v2c_d  [N_EDGE];
   logic signed [LLR_W-1:0] v2c_ld [N_EDGE];
   logic signed [LLR_W-1:0] c2v    [N_EDGE];
   logic [N_BITS-1:0]       dec;
   logic                    synd_zero, last_it, eval, finish;

   // input unpack with symmetric clamp of the most negative code
   for (genvar n = 0; n < N_BITS; n++) begin : g_in
      logic signed [LLR_W-1:0] raw;
      assign raw      = llr_i[n*LLR_W +: LLR_W];
      assign ch_in[n] = (raw[LLR_W-1] && (raw[LLR_W-2:0] == '0)) ? LLR_W'(-LIM) : raw;
   end

   // check nodes read registered bit-to-check messages
   for (genvar r = 0; r < M_CHK; r++) begin : g_chk
      localparam int DEG = row_deg(r);
      logic signed [LLR_W-1:0] vin  [DEG];
      logic signed [LLR_W-1:0] cout [DEG];
      for (genvar k = 0; k < DEG; k++) begin : g_edge
         localparam int E = edge_id(r, kth_col(r, k));
         assign vin[k] = v2c_q[E];
         assign c2v[E] = cout[k];
      end
      ldpc_chk_node #(.DEG(DEG), .W(LLR_W)) u_cn (
         .v2c_i (vin),
         .c2v_o (cout)
      );
   end

   // bit nodes produce next messages, posteriors and decisions
   for (genvar n = 0; n < N_BITS; n++) begin : g_bit
      localparam int DEG = col_deg(n);
      logic signed [LLR_W-1:0] cin  [DEG];
      logic signed [LLR_W-1:0] vout [DEG];
      for (genvar j = 0; j < DEG; j++) begin : g_edge
         localparam int E = edge_id(kth_row(n, j), n);
         assign cin[j]    = c2v[E];
         assign v2c_d[E]  = vout[j];
         assign v2c_ld[E] = ch_in[n];
      end
      ldpc_bit_node #(.DEG(DEG), .W(LLR_W)) u_bn (
         .ch_i   (ch_q[n]),
         .c2v_i  (cin),
         .v2c_o  (vout),
         .post_o (post[n])
      );
      assign dec[n] = ~post[n][LLR_W-1] & (post[n] != '0);
   end

   ldpc_syndrome u_syn (
      .word_i (dec),
      .zero_o (synd_zero)
   );

   assign it_now  = cnt_q + 1'b1;
   assign last_it = (it_now == IT_W'(MAX_ITER));
   assign eval    = chk_en_i | last_it;
   assign finish  = busy_q & eval & (synd_zero | last_it);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         hard_o  <= '0;
         ok_o    <= 1'b0;
         iters_o <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (busy_q) begin
            cnt_q <= it_now;
            if (finish) begin
               busy_q  <= 1'b0;
               done_o  <= 1'b1;
               hard_o  <= dec;
               ok_o    <= synd_zero;
               iters_o <= it_now;
            end
         end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!busy_q && start_i) begin
         ch_q  <= ch_in;
         v2c_q <= v2c_ld;
      end else if (busy_q) begin
         v2c_q <= v2c_d;
      end
   end

endmodule

// File: rtl/ldpc_mp_dec_chk.sv
module ldpc_mp_dec_chk import ldpc_mp_pkg::*; #(
   parameter int MAX_ITER = 50,
   parameter int IT_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chk_en_i,
   input logic [N_BITS-1:0] hard_o,
   input logic              ok_o,
   input logic [IT_W-1:0]   iters_o,
   input logic              done_o
);
   logic cw_ok;

   always_comb begin
      cw_ok = 1'b1;
      for (int r = 0; r < M_CHK; r++)
         if (^(hard_o & H_MAT[r])) cw_ok = 1'b0;
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);                                               // R8
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(hard_o) && $stable(ok_o) && $stable(iters_o))); // R8
   AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (iters_o != '0 && iters_o <= IT_W'(MAX_ITER)));          // R2
   AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !ok_o) |-> (iters_o == IT_W'(MAX_ITER)));                // R7
   AST_OK_IS_CODEWORD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ok_o) |-> cw_ok);                                        // R5
   AST_EARLY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && iters_o != IT_W'(MAX_ITER)) |-> $past(chk_en_i));        // R6

endmodule

bind ldpc_mp_dec ldpc_mp_dec_chk #(.MAX_ITER(MAX_ITER), .IT_W(IT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .chk_en_i (chk_en_i),
   .hard_o   (hard_o),
   .ok_o     (ok_o),
   .iters_o  (iters_o),
   .done_o   (done_o)
);

// File: tb/sim_ldpc_mp_dec.sv
`timescale 1ns/1ps
module sim_ldpc_mp_dec;
   localparam int NB = 10, W = 6, MAXI = 50, ITW = 6;

   logic          clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, chk_en_i = 1'b0;
   logic [NB*W-1:0] llr_i = '0;
   logic [NB-1:0] hard_o;
   logic          ok_o, done_o;
   logic [ITW-1:0] iters_o;

   ldpc_mp_dec u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .llr_i(llr_i),
      .chk_en_i(chk_en_i), .hard_o(hard_o), .ok_o(ok_o),
      .iters_o(iters_o), .done_o(done_o)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   int unsigned seed = 32'h1234_5678;

   // parity checks per R10, index 0 = bit 0
   logic [NB-1:0] hrow [5] = '{10'b1001100111, 10'b0110110101, 10'b1101011100,
                              10'b1010111010, 10'b0111001011};

   typedef struct { logic [NB-1:0] h; bit ok; int its; int at; } exp_t;
   exp_t q[$];

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int sat(input int x);
      return (x > 31) ? 31 : ((x < -31) ? -31 : x);
   endfunction

   task automatic model(input int raw[NB], input logic [63:0] en,
                        output logic [NB-1:0] h, output bit ok, output int its);
      int ch[NB];
      int v[5][NB];
      int c[5][NB];
      int tot, mn, a;
      bit s, z;
      h = '0; ok = 1'b0; its = 0;
      for (int n = 0; n < NB; n++) ch[n] = (raw[n] < -31) ? -31 : raw[n];
      for (int r = 0; r < 5; r++) for (int n = 0; n < NB; n++) v[r][n] = ch[n];
      for (int it = 1; it <= MAXI; it++) begin
         for (int r = 0; r < 5; r++)
            for (int n = 0; n < NB; n++)
               if (hrow[r][n]) begin
                  mn = 99; s = 1'b0;
                  for (int m = 0; m < NB; m++)
                     if (hrow[r][m] && m != n) begin
                        s = s ^ (v[r][m] < 0);
                        a = (v[r][m] < 0) ? -v[r][m] : v[r][m];
                        if (a < mn) mn = a;
                     end
                  c[r][n] = s ? -mn : mn;
               end
         for (int n = 0; n < NB; n++) begin
            tot = ch[n];
            for (int r = 0; r < 5; r++) if (hrow[r][n]) tot += c[r][n];
            h[n] = (sat(tot) > 0);
            for (int r = 0; r < 5; r++) if (hrow[r][n]) v[r][n] = sat(tot - c[r][n]);
         end
         if (en[it] || it == MAXI) begin
            z = 1'b1;
            for (int r = 0; r < 5; r++) if (^(h & hrow[r])) z = 1'b0;
            if (z || it == MAXI) begin
               ok = z; its = it;
               return;
            end
         end
      end
   endtask

   // driver: predicts, pushes to scoreboard, drives start and per-iteration enable
   task automatic run(input int raw[NB], input logic [63:0] en, input bit poke);
      logic [NB-1:0] h;
      bit ok;
      int its;
      exp_t e;
      model(raw, en, h, ok, its);
      @(negedge clk);
      for (int n = 0; n < NB; n++) llr_i[n*W +: W] = W'(raw[n]);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      e.h = h; e.ok = ok; e.its = its; e.at = cyc + its;
      q.push_back(e);
      chk_en_i = en[1];
      for (int k = 2; k <= its; k++) begin
         @(negedge clk);
         chk_en_i = en[k];
         if (poke && k == 3) begin
            llr_i   = ~llr_i;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      @(negedge clk);
      chk_en_i = 1'b0;
      start_i  = 1'b0;
      if (poke) begin
         check("R9 hard after busy start", int'(hard_o), int'(h));
         check("R9 iterations after busy start", int'(iters_o), its);
      end
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops expectations when the design reports a finished block
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n && done_o) begin
            if (q.size() == 0) begin
               total++; bad++;
               $display("FAIL R8: actual=done expected=idle");
            end else begin
               e = q.pop_front();
               check("R3 R4 R10 hard word", int'(hard_o), int'(e.h));
               check("R5 success flag", int'(ok_o), int'(e.ok));
               check("R6 R7 iteration count", int'(iters_o), e.its);
               check("R2 done timing", cyc, e.at);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int a[NB];
      logic [63:0] masks[4];
      masks[0] = '1;
      masks[1] = 64'h9249_2492_4924_9248;   // every third iteration
      masks[2] = ~64'h3F;                    // off for iterations 1..5
      masks[3] = '0;                         // never, only the limit

      repeat (3) @(negedge clk);
      check("R1 hard in reset", int'(hard_o), 0);
      check("R1 done in reset", int'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ok after reset", int'(ok_o), 0);
      check("R1 iterations after reset", int'(iters_o), 0);

      // strong all-zero codeword
      for (int n = 0; n < NB; n++) a[n] = -20;
      run(a, masks[0], 1'b0);
      check("R5 literal zero word", int'(hard_o), 0);
      check("R5 literal one iteration", int'(iters_o), 1);

      // strong all-ones codeword, held output
      for (int n = 0; n < NB; n++) a[n] = 20;
      run(a, masks[0], 1'b0);
      repeat (3) @(negedge clk);
      check("R8 R10 literal ones held", int'(hard_o), 10'h3FF);

      // zero posteriors decide 0
      for (int n = 0; n < NB; n++) a[n] = 0;
      run(a, masks[0], 1'b0);
      check("R4 literal zero posterior", int'(hard_o), 0);

      // most negative code clamps
      for (int n = 0; n < NB; n++) a[n] = -32;
      a[4] = 31;
      run(a, masks[0], 1'b0);

      // enable never high: forced evaluation at the limit
      for (int n = 0; n < NB; n++) a[n] = -20;
      run(a, masks[3], 1'b0);
      check("R6 R7 literal limit", int'(iters_o), MAXI);
      check("R7 literal ok at limit", int'(ok_o), 1);

      // single weak error, delayed enable
      for (int n = 0; n < NB; n++) a[n] = -12;
      a[3] = 5;
      run(a, masks[2], 1'b0);

      // start pulse while busy
      for (int n = 0; n < NB; n++) a[n] = -9;
      a[7] = 6;
      run(a, masks[2], 1'b1);

      // noisy blocks under every enable pattern
      for (int t = 0; t < 16; t++) begin
         for (int n = 0; n < NB; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            a[n] = int'((seed >> 16) % 25) - 15;
         end
         if (t == 15) for (int n = 0; n < NB; n++) a[n] = (n % 2 == 0) ? 3 : -3;
         run(a, masks[t % 4], 1'b0);
      end

      repeat (5) @(negedge clk);
      check("R8 pending results", q.size(), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule